// File: doc/BRIEF.md
# Split Floating-Point Status Register

This block holds the 32-bit floating-point status word as two 16-bit halves that commit on their own. The upper half records operand classification and the last compare result. The lower half records the flags raised by the current operation and the sticky flags gathered since they were last cleared. A compare or test unit writes the upper half, and an arithmetic unit writes the lower half. Both can commit in the same clock without arbitration.

Each flag bit of an update carries its own 3-bit mode, chosen by the execution unit for the instruction. A whole-register write port serves moves and restores. Two literal operations, AND and OR with a 16-bit immediate, reach only the lower half. The read port always shows the committed word, which is what a save or push captures. A one-cycle exception event is raised when an arithmetic update sets a current flag that software has enabled.

Top module: `fp_status_split`

## Requirements
- R1: After reset `rd_data` is 0 and `exc_evt` is 0.
- R2: A whole-register write loads `full_data & 32'h1F0F_7F7F` at the next clock. Bits [31:29], [23:20], [15] and [7] always read as 0. The layout is: class [28:24], compare [19:16], sticky [14:8], current [6:0].
- R3: When `full_we` is high, the whole-register write takes effect on both halves. Any upper, arithmetic or literal update in the same cycle is discarded.
- R4: An upper update (`hi_we`) applies, for each bit i of `hi_flags`, the mode `hi_mode[3i+2:3i]`. The mode codes are: 0 keep, 1 load flag, 2 clear, 3 clear-only (old AND flag), 4 set-only (old OR flag), and 5 to 7 keep. `hi_flags[8:4]` maps to [28:24] and `hi_flags[3:0]` maps to [19:16].
- R5: An arithmetic update (`lo_we`) applies the R4 modes to the current flags [6:0], using `lo_flags` and `lo_mode`. Each sticky bit [14+-8 offset] then becomes its old value OR the new value of the matching current flag.
- R6: An upper update and an arithmetic update in the same cycle both commit.
- R7: A literal operation (`lit_we`) combines bits [15:0] with `lit_imm`: AND when `lit_op`=0, OR when `lit_op`=1. Reserved bits stay 0 and bits [31:16] are unchanged. If an arithmetic update arrives in the same cycle, the literal operation wins.
- R8: `rd_data` shows the committed value until the clock edge, even while an update for either half is pending.
- R9: `exc_evt` is high for exactly the cycle after an arithmetic update commits in which some bit i has mode 1 or 4, `lo_flags[i]`=1 and `exc_en[i]`=1. A literal operation or whole-register write never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_we | input | 1 | Whole-register write |
| full_data | input | 32 | Whole-register write value |
| hi_we | input | 1 | Upper-half update strobe |
| hi_flags | input | 9 | Class [8:4] and compare [3:0] result bits |
| hi_mode | input | 27 | 3-bit mode per upper bit |
| lo_we | input | 1 | Arithmetic update strobe |
| lo_flags | input | 7 | Current-operation flag values |
| lo_mode | input | 21 | 3-bit mode per current flag |
| exc_en | input | 7 | Exception enable per current flag |
| lit_we | input | 1 | Literal operation strobe |
| lit_op | input | 1 | 0 AND, 1 OR |
| lit_imm | input | 16 | Literal immediate for bits [15:0] |
| rd_data | output | 32 | Committed status word |
| exc_evt | output | 1 | One-cycle exception event |

## Verification
The block has no parameters, so a single build covers every field position and every mode code. Random cycles mix all 8 mode codes on every bit, and they overlap all four write sources in one cycle. This exercises each precedence pair as well as the sticky accumulation across long runs of arithmetic updates. Directed cycles cover the edges of the reserved-bit mask, a literal OR that sets enabled flags without raising an event, and a read taken while a lower-half update is pending.

// File: rtl/fp_status_split.sv
module fp_status_split (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        full_we,
  input  logic [31:0] full_data,
  input  logic        hi_we,
  input  logic [8:0]  hi_flags,
  input  logic [26:0] hi_mode,
  input  logic        lo_we,
  input  logic [6:0]  lo_flags,
  input  logic [20:0] lo_mode,
  input  logic [6:0]  exc_en,
  input  logic        lit_we,
  input  logic        lit_op,
  input  logic [15:0] lit_imm,
  output logic [31:0] rd_data,
  output logic        exc_evt
);

  localparam int HI_N  = 9;
  localparam int EXC_N = 7;

  logic [HI_N-1:0]  hi_q, hi_nx;
  logic [EXC_N-1:0] cur_q, stk_q, cur_nx, set_hit;
  logic [EXC_N-1:0] cur_lit, stk_lit;
  logic             unused_bits;

  function automatic logic apply_mode(input logic old, input logic f, input logic [2:0] m);
    case (m)
      3'd1:    return f;
      3'd2:    return 1'b0;
      3'd3:    return old & f;
      3'd4:    return old | f;
      default: return old;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < HI_N; i++)
      hi_nx[i] = apply_mode(hi_q[i], hi_flags[i], hi_mode[3*i +: 3]);
    for (int i = 0; i < EXC_N; i++) begin
      cur_nx[i]  = apply_mode(cur_q[i], lo_flags[i], lo_mode[3*i +: 3]);
      set_hit[i] = lo_flags[i] && (lo_mode[3*i +: 3] == 3'd1 || lo_mode[3*i +: 3] == 3'd4);
    end
  end

  assign cur_lit = lit_op ? (cur_q | lit_imm[6:0])  : (cur_q & lit_imm[6:0]);
  assign stk_lit = lit_op ? (stk_q | lit_imm[14:8]) : (stk_q & lit_imm[14:8]);

  assign unused_bits = ^{full_data[31:29], full_data[23:20], full_data[15], full_data[7],
                         lit_imm[15], lit_imm[7]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      cur_q   <= '0;
      stk_q   <= '0;
      exc_evt <= 1'b0;
    end else begin
      exc_evt <= lo_we && !full_we && !lit_we && |(set_hit & exc_en);
      if (full_we)
        hi_q <= {full_data[28:24], full_data[19:16]};
      else if (hi_we)
        hi_q <= hi_nx;
      if (full_we) begin
        cur_q <= full_data[6:0];
        stk_q <= full_data[14:8];
      end else if (lit_we) begin
        cur_q <= cur_lit;
        stk_q <= stk_lit;
      end else if (lo_we) begin
        cur_q <= cur_nx;
        stk_q <= stk_q | cur_nx;
      end
    end
  end

  assign rd_data = {3'b000, hi_q[8:4], 4'b0000, hi_q[3:0], 1'b0, stk_q, 1'b0, cur_q};

  // R3
  full_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_we |=> rd_data == ($past(full_data) & 32'h1F0F_7F7F));

  // R7
  lit_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lit_we && !full_we && !hi_we) |=> rd_data[31:16] == $past(rd_data[31:16]));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_we && !lit_we) |=> ($past(rd_data[14:8]) & ~rd_data[14:8]) == 7'd0);

  // R9
  evt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_evt |-> ($past(lo_we) && !$past(lit_we) && !$past(full_we)));

  // R6
  hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !lo_we && !lit_we && !full_we) |=> $stable(rd_data[15:0]));

endmodule

// File: tb/fp_status_split_tb_top.sv
`timescale 1ns/1ps
module fp_status_split_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        full_we, hi_we, lo_we, lit_we, lit_op;
  logic [31:0] full_data;
  logic [8:0]  hi_flags;
  logic [26:0] hi_mode;
  logic [6:0]  lo_flags, exc_en;
  logic [20:0] lo_mode;
  logic [15:0] lit_imm;
  logic [31:0] rd_data;
  logic        exc_evt;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_rd;

  always #2 clk = ~clk;

  fp_status_split dut_i (.clk(clk), .rst_n(rst_n), .full_we(full_we), .full_data(full_data),
    .hi_we(hi_we), .hi_flags(hi_flags), .hi_mode(hi_mode), .lo_we(lo_we), .lo_flags(lo_flags),
    .lo_mode(lo_mode), .exc_en(exc_en), .lit_we(lit_we), .lit_op(lit_op), .lit_imm(lit_imm),
    .rd_data(rd_data), .exc_evt(exc_evt));

  function automatic logic mb(input logic o, input logic f, input logic [2:0] m);
    if (m == 3'd1) return f;
    if (m == 3'd2) return 1'b0;
    if (m == 3'd3) return o && f;
    if (m == 3'd4) return o || f;
    return o;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    full_we = 0; hi_we = 0; lo_we = 0; lit_we = 0; lit_op = 0;
    full_data = 0; hi_flags = 0; hi_mode = 0; lo_flags = 0; lo_mode = 0; exc_en = 0; lit_imm = 0;
  endtask

  task automatic cyc(input string tag);
    logic [31:0] nx;
    logic ev;
    int pos;
    nx = m_rd; ev = 0;
    if (hi_we || lo_we) chk("R8", rd_data, m_rd);
    if (full_we) nx = full_data & 32'h1F0F_7F7F;
    else begin
      if (hi_we)
        for (int i = 0; i < 9; i++) begin
          pos = (i >= 4) ? i + 20 : i + 16;
          nx[pos] = mb(m_rd[pos], hi_flags[i], hi_mode[3*i +: 3]);
        end
      if (lit_we) begin
        if (lit_op) nx[15:0] = m_rd[15:0] | (lit_imm & 16'h7F7F);
        else        nx[15:0] = m_rd[15:0] & lit_imm;
      end else if (lo_we)
        for (int i = 0; i < 7; i++) begin
          nx[i] = mb(m_rd[i], lo_flags[i], lo_mode[3*i +: 3]);
          nx[i+8] = m_rd[i+8] | nx[i];
          if (lo_flags[i] && exc_en[i] && (lo_mode[3*i +: 3] == 3'd1 || lo_mode[3*i +: 3] == 3'd4))
            ev = 1;
        end
    end
    @(posedge clk); @(negedge clk);
    m_rd = nx;
    chk(tag, rd_data, nx);
    chk("R9", {31'd0, exc_evt}, {31'd0, ev});
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string t;
    void'($urandom(32'd1234));
    idle(); rst_n = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", rd_data, 32'd0);
    chk("R1", {31'd0, exc_evt}, 32'd0);

    full_we = 1; full_data = 32'hFFFF_FFFF; cyc("R2"); idle();
    full_we = 1; full_data = 32'hA5A5_5A5A; cyc("R2"); idle();

    full_we = 1; full_data = 32'h0102_0304; hi_we = 1; hi_flags = 9'h1FF; hi_mode = {9{3'd1}};
    lo_we = 1; lo_flags = 7'h7F; lo_mode = {7{3'd4}}; exc_en = 7'h7F;
    lit_we = 1; lit_op = 1; lit_imm = 16'hFFFF; cyc("R3"); idle();

    hi_we = 1; hi_flags = 9'h155; hi_mode = {3'd1,3'd4,3'd3,3'd2,3'd0,3'd1,3'd4,3'd3,3'd7};
    lo_we = 1; lo_flags = 7'h2B; lo_mode = {3'd1,3'd1,3'd4,3'd2,3'd3,3'd4,3'd1};
    exc_en = 7'h01; cyc("R6"); idle();

    lit_we = 1; lit_op = 1; lit_imm = 16'hFFFF; exc_en = 7'h7F; cyc("R7"); idle();
    lit_we = 1; lit_op = 0; lit_imm = 16'h00F0; lo_we = 1; lo_flags = 7'h7F;
    lo_mode = {7{3'd1}}; exc_en = 7'h7F; cyc("R7"); idle();
    lo_we = 1; lo_flags = 7'h04; lo_mode = {7{3'd4}}; exc_en = 7'h04; cyc("R5"); idle();
    lo_we = 1; lo_flags = 7'h00; lo_mode = {7{3'd2}}; cyc("R5"); idle();
    hi_we = 1; hi_flags = 9'h000; hi_mode = {9{3'd3}}; cyc("R4"); idle();

    for (int n = 0; n < 3000; n++) begin
      full_we = ($urandom % 10) == 0;
      full_data = $urandom;
      hi_we = $urandom % 2; hi_flags = 9'($urandom); hi_mode = 27'($urandom);
      lo_we = $urandom % 2; lo_flags = 7'($urandom); lo_mode = 21'($urandom);
      exc_en = 7'($urandom);
      lit_we = ($urandom % 5) == 0; lit_op = $urandom % 2; lit_imm = 16'($urandom);
      if (full_we) t = "R3";
      else if (lit_we) t = "R7";
      else if (hi_we && lo_we) t = "R6";
      else if (lo_we) t = "R5";
      else t = "R4";
      cyc(t);
      if ((n % 97) == 0) begin idle(); cyc("R4"); end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule